// File: doc/BRIEF.md
# SRAM-Backed Ternary Match Table

This block searches a table of ternary rules using ordinary dual-port RAM in place of ternary cells. The 32-bit search key is cut into four 8-bit slices, and each slice has its own 256-word RAM. Every RAM address stands for one concrete value of its slice. The word stored at that address holds one bit per rule entry, and that bit is set when the entry's rule accepts that slice value. A search reads one word from each RAM in the same cycle. It ANDs the four entry vectors together with a register of live entries. A priority encoder then reports the lowest-numbered entry that matches.

Rules are installed through the second RAM port. A rule is a data word and a mask word. The update controller steps through all 256 addresses, one per cycle. At each address it writes the chosen entry's bit in all four RAMs: the bit is one where the slice value is covered by the rule and zero where it is not. This sweep replaces any older rule held by that entry. An erase runs the same sweep but clears the bit everywhere. Searches keep running on the first port while a sweep is in progress.

Top module: `tern_match_table`

## Requirements
- R1: A rule is a data word D and a mask word M, each 32 bits. A mask bit of 1 means the key bit must equal the D bit, and a mask bit of 0 means that key bit is ignored. After a write, the entry matches exactly the keys for which ((key ^ D) & M) == 0.
- R2: A search request (srchValid high at a rising edge) gives resValid high after the next rising edge. resHit and resIndex for that key are valid in that same cycle. resValid is low in every cycle that does not follow a request.
- R3: When no entry matches, resHit is 0 and resIndex is 0.
- R4: When several entries match, resIndex is the lowest matching entry number.
- R5: A write (updErase = 0) to an entry replaces its previous rule, so keys accepted only by the old rule no longer hit that entry.
- R6: An erase (updErase = 1) makes the entry match no key.
- R7: An update is accepted only when updValid is high and updBusy is low at a rising edge. updBusy then goes high after that edge and stays high for exactly 256 cycles. An updValid raised while updBusy is high is ignored and changes no entry.
- R8: While an update is in progress, the entry being updated does not hit. All other entries keep answering searches.
- R9: After reset, updBusy and resValid are low and no entry matches any key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srchValid | input | 1 | Search request |
| srchKey | input | 32 | Search key |
| updValid | input | 1 | Update request |
| updErase | input | 1 | 1 = erase the entry, 0 = write the rule |
| updEntry | input | 6 | Entry number to update |
| updData | input | 32 | Rule data word |
| updMask | input | 32 | Rule mask word, 1 = bit compared |
| updBusy | output | 1 | Update sweep in progress |
| resValid | output | 1 | Search result valid |
| resHit | output | 1 | At least one entry matched |
| resIndex | output | 6 | Lowest matching entry, 0 on a miss |

## Verification
A search result is due in the cycle after the request edge. The bench raises srchValid for one edge and samples resValid, resHit and resIndex at the falling edge that follows, so it always reads the registered result of that one request. An update holds updBusy for 256 cycles starting one edge after it is accepted. The bench counts falling edges with updBusy high to check that length, and it only treats a rule as installed once updBusy has dropped. Searches made in the middle of a sweep are placed several cycles after acceptance, so the entry being swept is known to be masked out.

// File: rtl/tm_pkg.sv
package tm_pkg;
  // Strobes from the update controller to the datapath
  typedef struct packed {
    logic wrEn;       // write one address of every partition RAM
    logic dropValid;  // mark the swept entry as not live
    logic markValid;  // mark the swept entry as live
  } tmStrobe_t;
endpackage

// File: rtl/tm_ram.sv
module tm_ram #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int BW = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rdEn,
  input  logic [AW-1:0]    rdAddr,
  output logic [WIDTH-1:0] rdData,
  input  logic             wrEn,
  input  logic [AW-1:0]    wrAddr,
  input  logic [BW-1:0]    wrBit,
  input  logic             wrVal
);
  logic [WIDTH-1:0] mem [DEPTH];

  // Read port: a collision with the write port returns the old word
  always_ff @(posedge clk) begin
    if (rdEn) rdData <= mem[rdAddr];
  end

  // Write port: single-bit write
  always_ff @(posedge clk) begin
    if (wrEn) mem[wrAddr][wrBit] <= wrVal;
  end
endmodule

// File: rtl/tm_ctrl.sv
module tm_ctrl
  import tm_pkg::*;
#(
  parameter int KEY_W   = 32,
  parameter int SUB_W   = 8,
  parameter int ENTRIES = 64,
  localparam int NPART = KEY_W / SUB_W,
  localparam int DEPTH = 1 << SUB_W,
  localparam int EW    = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             updValid,
  input  logic             updErase,
  input  logic [EW-1:0]    updEntry,
  input  logic [KEY_W-1:0] updData,
  input  logic [KEY_W-1:0] updMask,
  output logic             updBusy,
  output tmStrobe_t        strobe,
  output logic [SUB_W-1:0] wrAddr,
  output logic [EW-1:0]    wrEntry,
  output logic [NPART-1:0] wrSet
);
  logic             busyQ;
  logic [SUB_W-1:0] cntQ;
  logic             eraseQ;
  logic [EW-1:0]    entryQ;
  logic [KEY_W-1:0] dataQ;
  logic [KEY_W-1:0] maskQ;
  logic             accept;
  logic             lastAddr;

  assign accept   = updValid && !busyQ;
  assign lastAddr = (cntQ == SUB_W'(DEPTH - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      cntQ   <= '0;
      eraseQ <= 1'b0;
      entryQ <= '0;
      dataQ  <= '0;
      maskQ  <= '0;
    end else if (accept) begin
      busyQ  <= 1'b1;
      cntQ   <= '0;
      eraseQ <= updErase;
      entryQ <= updEntry;
      dataQ  <= updData;
      maskQ  <= updMask;
    end else if (busyQ) begin
      cntQ <= cntQ + 1'b1;
      if (lastAddr) busyQ <= 1'b0;
    end
  end

  // Per-partition coverage of the current sweep address
  for (genvar p = 0; p < NPART; p++) begin : g_cover
    always_comb begin
      wrSet[p] = !eraseQ &&
                 (((cntQ ^ dataQ[p*SUB_W +: SUB_W]) & maskQ[p*SUB_W +: SUB_W]) == '0);
    end
  end

  always_comb begin
    strobe.wrEn      = busyQ;
    strobe.dropValid = busyQ && (cntQ == '0);
    strobe.markValid = busyQ && lastAddr && !eraseQ;
  end

  assign wrAddr  = cntQ;
  assign wrEntry = entryQ;
  assign updBusy = busyQ;
endmodule

// File: rtl/tm_dpath.sv
module tm_dpath
  import tm_pkg::*;
#(
  parameter int KEY_W   = 32,
  parameter int SUB_W   = 8,
  parameter int ENTRIES = 64,
  localparam int NPART = KEY_W / SUB_W,
  localparam int DEPTH = 1 << SUB_W,
  localparam int EW    = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             srchValid,
  input  logic [KEY_W-1:0] srchKey,
  input  tmStrobe_t        strobe,
  input  logic [SUB_W-1:0] wrAddr,
  input  logic [EW-1:0]    wrEntry,
  input  logic [NPART-1:0] wrSet,
  output logic             resValid,
  output logic             resHit,
  output logic [EW-1:0]    resIndex
);
  logic [ENTRIES-1:0] rdVec [NPART];
  logic [ENTRIES-1:0] liveQ;
  logic [ENTRIES-1:0] liveSnapQ;
  logic               resValidQ;
  logic [ENTRIES-1:0] matchVec;

  for (genvar p = 0; p < NPART; p++) begin : g_part
    tm_ram #(.DEPTH(DEPTH), .WIDTH(ENTRIES)) u_ram (
      .clk    (clk),
      .rdEn   (srchValid),
      .rdAddr (srchKey[p*SUB_W +: SUB_W]),
      .rdData (rdVec[p]),
      .wrEn   (strobe.wrEn),
      .wrAddr (wrAddr),
      .wrBit  (wrEntry),
      .wrVal  (wrSet[p])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      liveQ     <= '0;
      liveSnapQ <= '0;
      resValidQ <= 1'b0;
    end else begin
      if (strobe.dropValid) liveQ[wrEntry] <= 1'b0;
      else if (strobe.markValid) liveQ[wrEntry] <= 1'b1;
      if (srchValid) liveSnapQ <= liveQ;
      resValidQ <= srchValid;
    end
  end

  always_comb begin
    matchVec = liveSnapQ;
    for (int p = 0; p < NPART; p++) matchVec &= rdVec[p];
  end

  // Lowest-index priority encoder
  always_comb begin
    resHit   = |matchVec;
    resIndex = '0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (matchVec[e]) resIndex = EW'(e);
    end
  end

  assign resValid = resValidQ;
endmodule

// File: rtl/tern_match_table.sv
module tern_match_table
  import tm_pkg::*;
#(
  parameter int KEY_W   = 32,
  parameter int SUB_W   = 8,
  parameter int ENTRIES = 64,
  localparam int NPART = KEY_W / SUB_W,
  localparam int EW    = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             srchValid,
  input  logic [KEY_W-1:0] srchKey,
  input  logic             updValid,
  input  logic             updErase,
  input  logic [EW-1:0]    updEntry,
  input  logic [KEY_W-1:0] updData,
  input  logic [KEY_W-1:0] updMask,
  output logic             updBusy,
  output logic             resValid,
  output logic             resHit,
  output logic [EW-1:0]    resIndex
);
  tmStrobe_t        strobe;
  logic [SUB_W-1:0] wrAddr;
  logic [EW-1:0]    wrEntry;
  logic [NPART-1:0] wrSet;

  tm_ctrl #(.KEY_W(KEY_W), .SUB_W(SUB_W), .ENTRIES(ENTRIES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .updValid (updValid),
    .updErase (updErase),
    .updEntry (updEntry),
    .updData  (updData),
    .updMask  (updMask),
    .updBusy  (updBusy),
    .strobe   (strobe),
    .wrAddr   (wrAddr),
    .wrEntry  (wrEntry),
    .wrSet    (wrSet)
  );

  tm_dpath #(.KEY_W(KEY_W), .SUB_W(SUB_W), .ENTRIES(ENTRIES)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .srchValid (srchValid),
    .srchKey   (srchKey),
    .strobe    (strobe),
    .wrAddr    (wrAddr),
    .wrEntry   (wrEntry),
    .wrSet     (wrSet),
    .resValid  (resValid),
    .resHit    (resHit),
    .resIndex  (resIndex)
  );
endmodule

// File: rtl/tern_match_table_chk.sv
module tern_match_table_chk #(
  parameter int DEPTH = 256,
  parameter int EW    = 6,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          srchValid,
  input logic          updValid,
  input logic          updBusy,
  input logic          resValid,
  input logic          resHit,
  input logic [EW-1:0] resIndex
);
  logic [CW-1:0] busyCnt;

  always_ff @(posedge clk) begin
    if (!rstN) busyCnt <= '0;
    else if (updBusy) busyCnt <= busyCnt + 1'b1;
    else busyCnt <= '0;
  end

  p_res_follows_req_r2: assert property (@(posedge clk) disable iff (!rstN)
    srchValid |=> resValid);

  p_res_only_after_req_r2: assert property (@(posedge clk) disable iff (!rstN)
    !srchValid |=> !resValid);

  p_miss_index_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !resHit) |-> (resIndex == '0));

  p_busy_starts_r7: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && !updBusy) |=> updBusy);

  p_busy_bounded_r7: assert property (@(posedge clk) disable iff (!rstN)
    updBusy |-> (busyCnt < CW'(DEPTH)));

  p_busy_full_length_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(updBusy) |-> ($past(busyCnt) == CW'(DEPTH - 1)));
endmodule

bind tern_match_table tern_match_table_chk #(.DEPTH(1 << SUB_W), .EW(EW)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .srchValid (srchValid),
  .updValid  (updValid),
  .updBusy   (updBusy),
  .resValid  (resValid),
  .resHit    (resHit),
  .resIndex  (resIndex)
);

// File: tb/tb_tern_match_table.sv
module tb_tern_match_table;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        srchValid = 1'b0;
  logic [31:0] srchKey = '0;
  logic        updValid = 1'b0;
  logic        updErase = 1'b0;
  logic [5:0]  updEntry = '0;
  logic [31:0] updData = '0;
  logic [31:0] updMask = '0;
  logic        updBusy;
  logic        resValid;
  logic        resHit;
  logic [5:0]  resIndex;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  tern_match_table dut (
    .clk(clk), .rstN(rstN), .srchValid(srchValid), .srchKey(srchKey),
    .updValid(updValid), .updErase(updErase), .updEntry(updEntry),
    .updData(updData), .updMask(updMask), .updBusy(updBusy),
    .resValid(resValid), .resHit(resHit), .resIndex(resIndex)
  );

  typedef struct packed {
    logic [31:0] key;
    logic        hit;
    logic [5:0]  idx;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{key: 32'h0A0B0C0D, hit: 1'b1, idx: 6'd3},
    '{key: 32'h0A110000, hit: 1'b1, idx: 6'd3},
    '{key: 32'hC0A80177, hit: 1'b1, idx: 6'd10},
    '{key: 32'hC0A802F5, hit: 1'b1, idx: 6'd20},
    '{key: 32'h12345678, hit: 1'b1, idx: 6'd63},
    '{key: 32'h12345679, hit: 1'b0, idx: 6'd0},
    '{key: 32'h0B000000, hit: 1'b0, idx: 6'd0},
    '{key: 32'hC0A801F0, hit: 1'b1, idx: 6'd10},
    '{key: 32'hFFFFFFFF, hit: 1'b1, idx: 6'd20}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitIdle();
    while (updBusy) @(negedge clk);
  endtask

  task automatic startUpdate(input logic [5:0] e, input logic er,
                             input logic [31:0] d, input logic [31:0] m);
    updValid = 1'b1; updErase = er; updEntry = e; updData = d; updMask = m;
    @(negedge clk);
    updValid = 1'b0;
  endtask

  task automatic update(input logic [5:0] e, input logic er,
                        input logic [31:0] d, input logic [31:0] m);
    waitIdle();
    startUpdate(e, er, d, m);
    waitIdle();
  endtask

  task automatic search(input logic [31:0] k, input string req,
                        input logic expHit, input logic [5:0] expIdx);
    srchValid = 1'b1; srchKey = k;
    @(negedge clk);
    srchValid = 1'b0;
    check({req, " resValid"}, 32'(resValid), 32'd1);
    check({req, " resHit"}, 32'(resHit), 32'(expHit));
    check({req, " resIndex"}, 32'(resIndex), 32'(expIdx));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    int busyCycles;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9: reset state
    check("R9 updBusy", 32'(updBusy), 32'd0);
    check("R9 resValid", 32'(resValid), 32'd0);
    search(32'h00000000, "R9 empty table", 1'b0, 6'd0);
    @(negedge clk);
    check("R2 resValid drops", 32'(resValid), 32'd0);

    // R1: install rules
    update(6'd3,  1'b0, 32'h0A000000, 32'hFF000000);
    update(6'd5,  1'b0, 32'h0A0B0000, 32'hFFFF0000);
    update(6'd10, 1'b0, 32'hC0A80100, 32'hFFFFFF00);
    update(6'd20, 1'b0, 32'h000000F0, 32'h000000F0);
    update(6'd63, 1'b0, 32'h12345678, 32'hFFFFFFFF);

    // R1 R2 R3 R4: vector table
    for (int i = 0; i < NVEC; i++) begin
      search(VECS[i].key, "R1/R4 vector", VECS[i].hit, VECS[i].idx);
    end

    // R7: busy length
    waitIdle();
    startUpdate(6'd10, 1'b0, 32'hC0A80100, 32'hFFFFFF00);
    busyCycles = 0;
    // R8: entry under update is masked, others still answer
    repeat (3) @(negedge clk);
    search(32'hC0A80177, "R8 swept entry", 1'b0, 6'd0);
    search(32'h12345678, "R8 other entry", 1'b1, 6'd63);
    // R7: request while busy must be ignored
    startUpdate(6'd1, 1'b0, 32'h0B000000, 32'hFF000000);
    busyCycles = 6;
    while (updBusy) begin
      busyCycles++;
      @(negedge clk);
    end
    check("R7 busy cycles", 32'(busyCycles), 32'd256);
    search(32'hC0A80177, "R8 entry restored", 1'b1, 6'd10);
    search(32'h0B000000, "R7 ignored request", 1'b0, 6'd0);

    // R7: busy goes high exactly after acceptance
    startUpdate(6'd7, 1'b1, 32'h0, 32'h0);
    check("R7 busy after accept", 32'(updBusy), 32'd1);
    waitIdle();

    // R6: erase entry 3
    update(6'd3, 1'b1, 32'h0, 32'h0);
    search(32'h0A0B0C0D, "R6 erased entry", 1'b1, 6'd5);
    search(32'h0A110000, "R6 erased entry", 1'b0, 6'd0);

    // R5: rewrite entry 5
    update(6'd5, 1'b0, 32'h55000000, 32'hFF000000);
    search(32'h0A0B0C0D, "R5 old rule gone", 1'b0, 6'd0);
    search(32'h55123456, "R5 new rule", 1'b1, 6'd5);

    // R4: full wildcard at entry 0 wins over everything
    update(6'd0, 1'b0, 32'hDEADBEEF, 32'h00000000);
    search(32'h12345678, "R4 lowest index", 1'b1, 6'd0);
    search(32'hC0A801F0, "R4 lowest index", 1'b1, 6'd0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule